// File: doc/BRIEF.md
# Channel Volume Envelope

This block holds the 4-bit output volume of one sound channel and moves it one unit at a time, up or down, on a programmable number of envelope ticks. Software programs it through a single byte that carries the starting level, the direction of travel and the pace. A frame sequencer supplies the envelope ticks as one-cycle strobes. A channel trigger restarts the envelope from the last programmed byte. The channel-enable flag gates the stepping.

The volume stops at the top and bottom of its range. Once a step lands on either limit, the envelope switches itself off and stays off until the byte is written again or the channel is triggered. A pace of zero programs a constant volume.

Top module: `vol_envelope`

## Requirements
- R1: After reset the volume output is 0 and the active flag is 0.
- R2: A write of the envelope byte takes effect on the next clock edge. Bits 7:4 become the volume. The active flag becomes 1 exactly when bits 2:0 (the pace) are nonzero.
- R3: With pace P nonzero and the channel enabled, the volume changes once every P envelope ticks, on the P-th tick. It does not change on the ticks between.
- R4: Bit 3 of the byte selects the direction: 1 raises the volume by one per step and 0 lowers it by one.
- R5: A step that lands on 15 or 0 clears the active flag. After that, further ticks leave the volume unchanged. A byte that already starts at a limit with a matching direction is still active, and its first step clears the flag without moving the volume.
- R6: With pace 0 the active flag is 0 and envelope ticks never change the volume.
- R7: Ticks that arrive while the channel-enable input is low are ignored. The partial pace count is kept and resumes when the enable returns.
- R8: Every write of the byte restarts the pace count from zero, discarding ticks that were already counted.
- R9: A trigger reloads the volume from bits 7:4 of the last written byte, restarts the pace count, and sets the active flag if that byte's pace is nonzero. This applies also after the envelope has stopped.
- R10: The volume changes only on a write, a trigger, or an enabled tick that completes the pace. Each such tick moves it by at most one.
- R11: If a write and a trigger arrive in the same cycle, the newly written byte supplies the volume and the active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the envelope byte |
| cfg_data | input | 8 | Envelope byte: [7:4] start volume, [3] direction, [2:0] pace |
| env_tick | input | 1 | One-cycle envelope tick from the frame sequencer |
| trig | input | 1 | One-cycle channel trigger |
| chan_en | input | 1 | Channel enabled; ticks are ignored while low |
| vol | output | 4 | Current volume |
| env_active | output | 1 | Envelope still stepping |

## Verification
The bench checks the limits in both directions. A design that wraps instead of saturating would show 0 after 15 or 15 after 0. A design that never stops would keep the active flag high at a limit. Bytes that start at a limit check that the first step neither moves the volume nor leaves the envelope running. Partial pace counts are probed across a rewrite and across a low channel enable. Losing or keeping the count wrongly there shows up as a step one tick early or late. Trigger after a stop, pace zero, and a write coinciding with a trigger catch designs that reload from the wrong source or fail to rearm.

// File: rtl/env_pkg.sv
// Shared widths and the envelope byte layout.
package env_pkg;
    parameter int ENV_VOL_W  = 4;
    parameter int ENV_PACE_W = 3;
    parameter int ENV_CFG_W  = ENV_VOL_W + 1 + ENV_PACE_W;

    // Byte layout: start volume in the top bits, direction, pace at the bottom.
    typedef struct packed {
        logic [ENV_VOL_W-1:0]  init_vol;
        logic                  dir_up;
        logic [ENV_PACE_W-1:0] pace;
    } env_cfg_t;
endpackage

// File: rtl/env_decode.sv
// Envelope byte decoder and holding register.
// Keeps the last written byte for later triggers. Produces one load strobe,
// plus the volume and active state to load. A write in the same cycle as a
// trigger supplies the values. Assumes cfg_we and trig are one-cycle strobes.
module env_decode
    import env_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ENV_CFG_W-1:0] cfg_data,
    input  logic                 trig,
    output env_cfg_t             cfg,
    output logic                 load,
    output logic [ENV_VOL_W-1:0] load_vol,
    output logic                 load_act
);
    env_cfg_t wr_cfg;
    env_cfg_t src_cfg;

    assign wr_cfg = env_cfg_t'(cfg_data);

    // Pick the byte that drives a load: the incoming one on a write, else the stored one.
    always_comb begin
        src_cfg  = cfg_we ? wr_cfg : cfg;
        load     = cfg_we | trig;
        load_vol = src_cfg.init_vol;
        load_act = (src_cfg.pace != '0);
    end

    // Hold the last written byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (cfg_we)
            cfg <= wr_cfg;
    end

    // R8: a write replaces the stored byte by the next edge.
    a_r8_byte_stored: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg == env_cfg_t'($past(cfg_data))));
endmodule

// File: rtl/env_pacer.sv
// Pace counter.
// Counts enabled ticks while the envelope is active. It raises step on the
// tick that brings the count to the programmed pace, then starts over.
// Assumes the count starts at zero whenever pace changes, which the load strobe guarantees.
module env_pacer
    import env_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  env_tick,
    input  logic                  chan_en,
    input  logic                  active,
    input  logic [ENV_PACE_W-1:0] pace,
    output logic                  step
);
    logic [ENV_PACE_W-1:0] cnt;
    logic [ENV_PACE_W-1:0] cnt_inc;
    logic                  advance;
    logic                  at_pace;

    // Decide whether this tick counts and whether it completes the pace.
    always_comb begin
        advance = env_tick & chan_en & active & ~load;
        cnt_inc = cnt + 1'b1;
        at_pace = (cnt_inc >= pace);
        step    = advance & at_pace;
    end

    // Advance, wrap or clear the pace count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= '0;
        else if (advance)
            cnt <= at_pace ? '0 : cnt_inc;
    end

    // R3: while active the count never reaches the pace, so it cannot overflow.
    a_r3_cnt_below_pace: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < pace));

    // R7: without an enabled tick or a load the count holds.
    a_r7_cnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(env_tick && chan_en)) |=> $stable(cnt));
endmodule

// File: rtl/env_level.sv
// Volume level register.
// Loads the volume on a write or trigger. Moves it one unit per step in the
// programmed direction and saturates at the range ends. Clears the active
// flag when a step lands on either end. Assumes step is only raised while active.
module env_level
    import env_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [ENV_VOL_W-1:0] load_vol,
    input  logic                 load_act,
    input  logic                 step,
    input  logic                 dir_up,
    output logic [ENV_VOL_W-1:0] vol,
    output logic                 active
);
    localparam logic [ENV_VOL_W-1:0] VOL_MAX = '1;

    logic [ENV_VOL_W-1:0] vol_nxt;
    logic                 at_limit;

    // Saturating one-unit move in the programmed direction.
    always_comb begin
        if (dir_up)
            vol_nxt = (vol == VOL_MAX) ? vol : vol + 1'b1;
        else
            vol_nxt = (vol == '0) ? vol : vol - 1'b1;
        at_limit = (vol_nxt == '0) || (vol_nxt == VOL_MAX);
    end

    // Load, step or hold the volume and the active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol    <= '0;
            active <= 1'b0;
        end else if (load) begin
            vol    <= load_vol;
            active <= load_act;
        end else if (step) begin
            vol <= vol_nxt;
            if (at_limit)
                active <= 1'b0;
        end
    end

    // R10: without a load or a step the volume holds.
    a_r10_vol_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(vol));

    // R5: the envelope only goes inactive on a limit.
    a_r5_stop_only_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load) |=> (active || vol == '0 || vol == VOL_MAX));

    // R5: a stopped envelope stays stopped until reloaded.
    a_r5_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load) |=> !active);

    // R6: a load with zero pace leaves the envelope inactive.
    a_r6_zero_pace_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !load_act) |=> !active);
endmodule

// File: rtl/vol_envelope.sv
// Channel volume envelope, top level.
// Ties the byte decoder, the pace counter and the level register together.
// Assumes env_tick, trig and cfg_we are one-cycle strobes in the clk domain.
module vol_envelope
    import env_pkg::*;
#(
    parameter int VOL_W  = ENV_VOL_W,
    parameter int CFG_W  = ENV_CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             env_tick,
    input  logic             trig,
    input  logic             chan_en,
    output logic [VOL_W-1:0] vol,
    output logic             env_active
);
    env_cfg_t             cfg;
    logic                 load;
    logic [ENV_VOL_W-1:0] load_vol;
    logic                 load_act;
    logic                 step;
    logic [ENV_VOL_W-1:0] vol_i;

    env_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_data (cfg_data),
        .trig     (trig),
        .cfg      (cfg),
        .load     (load),
        .load_vol (load_vol),
        .load_act (load_act)
    );

    env_pacer u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .env_tick (env_tick),
        .chan_en  (chan_en),
        .active   (env_active),
        .pace     (cfg.pace),
        .step     (step)
    );

    env_level u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_vol (load_vol),
        .load_act (load_act),
        .step     (step),
        .dir_up   (cfg.dir_up),
        .vol      (vol_i),
        .active   (env_active)
    );

    assign vol = vol_i;

    // R10: one tick moves the volume by at most one unit.
    a_r10_single_unit: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we || trig) |=> (vol == $past(vol) || vol == $past(vol) + 1'b1
                               || vol == $past(vol) - 1'b1));
endmodule

// File: tb/sim_vol_envelope.sv
module sim_vol_envelope;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_data = '0;
    logic       env_tick = 1'b0;
    logic       trig = 1'b0;
    logic       chan_en = 1'b1;
    logic [3:0] vol;
    logic       env_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    vol_envelope u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .env_tick(env_tick), .trig(trig), .chan_en(chan_en),
        .vol(vol), .env_active(env_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input int ev, input int ea);
        chk({req, " vol"}, int'(vol), ev);
        chk({req, " active"}, int'(env_active), ea);
    endtask

    // Inputs change at falling edges; outputs are sampled at the next falling edge.
    task automatic wr(input logic [7:0] b);
        cfg_we = 1'b1; cfg_data = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic tick();
        env_tick = 1'b1;
        @(negedge clk);
        env_tick = 1'b0;
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic t_reset();
        chk_state("R1 reset", 0, 0);
    endtask

    task automatic t_pace_down();
        wr(8'h52);                      // vol 5, down, pace 2
        chk_state("R2 load", 5, 1);
        tick();
        chk_state("R3 mid-pace", 5, 1);
        tick();
        chk_state("R3 R4 down step", 4, 1);
        tick(); tick();
        chk("R3 second step", int'(vol), 3);
    endtask

    task automatic t_up();
        wr(8'h39);                      // vol 3, up, pace 1
        tick();
        chk("R4 up step", int'(vol), 4);
        tick();
        chk("R4 up step 2", int'(vol), 5);
    endtask

    task automatic t_saturate();
        wr(8'hD9);                      // 13 up pace 1
        tick(); chk_state("R5 up 14", 14, 1);
        tick(); chk_state("R5 top stop", 15, 0);
        tick(); chk_state("R5 stays top", 15, 0);
        wr(8'h11);                      // 1 down pace 1
        tick(); chk_state("R5 bottom stop", 0, 0);
        tick(); chk_state("R5 stays bottom", 0, 0);
        wr(8'hF9);                      // start at 15 going up
        chk_state("R5 start at limit", 15, 1);
        tick(); chk_state("R5 limit first step", 15, 0);
        wr(8'h01);                      // start at 0 going down
        tick(); chk_state("R5 zero first step", 0, 0);
    endtask

    task automatic t_zero_pace();
        wr(8'h78);                      // 7 up pace 0
        chk_state("R6 zero pace", 7, 0);
        for (int i = 0; i < 4; i++) tick();
        chk("R6 ticks ignored", int'(vol), 7);
    endtask

    task automatic t_chan_gate();
        wr(8'h83);                      // 8 down pace 3
        tick(); tick();
        chan_en = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        chk("R7 gated", int'(vol), 8);
        chan_en = 1'b1;
        tick();
        chk("R7 count resumed", int'(vol), 7);
    endtask

    task automatic t_restart();
        wr(8'h83);
        tick(); tick();
        wr(8'h83);
        tick(); tick();
        chk("R8 count restarted", int'(vol), 8);
        tick();
        chk("R8 step after full pace", int'(vol), 7);
    endtask

    task automatic t_trigger();
        wr(8'hA1);                      // 10 down pace 1
        tick(); tick();
        chk("R9 pre-trigger", int'(vol), 8);
        pulse_trig();
        chk_state("R9 reload", 10, 1);
        tick();
        chk("R9 steps after trigger", int'(vol), 9);
        wr(8'h21);                      // 2 down pace 1
        tick(); tick();
        chk_state("R9 stopped", 0, 0);
        pulse_trig();
        chk_state("R9 rearmed", 2, 1);
        tick();
        chk("R9 rearmed step", int'(vol), 1);
    endtask

    task automatic t_write_and_trig();
        wr(8'h90);                      // stored byte: 9, pace 0
        cfg_we = 1'b1; cfg_data = 8'h4B; trig = 1'b1;   // 4 up pace 3
        @(negedge clk);
        cfg_we = 1'b0; trig = 1'b0;
        chk_state("R11 write wins", 4, 1);
        tick(); tick();
        chk("R10 no step mid-pace", int'(vol), 4);
        tick();
        chk("R10 one unit step", int'(vol), 5);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pace_down();
        t_up();
        t_saturate();
        t_zero_pace();
        t_chan_gate();
        t_restart();
        t_trigger();
        t_write_and_trig();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule